// File: doc/BRIEF.md
# Eight-bit Timer with Software-Forced Compare

This block is an 8-bit timer/counter with a selectable prescaled count enable, two compare channels (A and B) and one waveform pin per channel. Software reaches it through a plain write port (`wr_en`, `wr_addr`, `wr_data`) and a combinational read port (`rd_addr`, `rd_data`). The counter either free-runs and wraps, or, in clear-on-compare (CTC) mode, restarts from zero after it reaches the channel A compare value. Each genuine compare match applies the channel's pin action and raises a sticky interrupt flag.

A second control register carries two force strobes. Writing a 1 to a strobe applies that channel's pin action at once, exactly as a real match would. It sets no flag, never restarts the counter and is ignored while the waveform mode is a PWM mode. The strobes are not stored, so they always read back as zero.

The asynchronous active-low reset is released synchronously, two clock edges after `rst_n` rises.

Top module: `fc_timer8`

## Requirements
- R1: After reset every register reads 0, both waveform pins are low and all three interrupt flags are low.
- R2: The register map is: address 0 mode register, address 1 control register, address 2 compare A, address 3 compare B, address 4 counter, address 5 flags. The control register stores bit 3 (mode high bit) and bits 2:0 (clock select). Its bits 7:4 always read as 0: bits 5:4 are reserved, and bits 7 (force A) and 6 (force B) are strobes.
- R3: The clock select codes behave as follows. 000, 110 and 111 hold the counter. 001 advances it on every clock, 010 on every 8th, 011 on every 64th, 100 on every 256th and 101 on every 1024th, from a free-running 10-bit prescaler.
- R4: The waveform mode is {control bit 3, mode register bits 1:0}, and code 000 is normal mode. In normal mode the counter counts up and wraps from 255 to 0, and each wrap sets the overflow flag (flags bit 0).
- R5: Mode code 010 is CTC. In CTC, a counting tick with the counter equal to compare A loads 0 instead of incrementing and sets no overflow flag. Above compare A the counter keeps counting up.
- R6: A counting tick with the counter equal to a compare value sets that channel's flag (bit 1 for A, bit 2 for B). Flags stay set until software writes 1 to that bit at address 5.
- R7: Mode register bits 7:6 (channel A) and 5:4 (channel B) pick the pin action: 00 disconnects the pin (reads low, state kept), 01 toggles, 10 clears, 11 sets. The action is applied on each genuine match.
- R8: In a non-PWM mode, writing 1 to a force bit applies that channel's action from its current mode field on the write's clock edge. The write sets no flag and does not change the counter, even in CTC when the counter equals compare A.
- R9: A mode with bit 0 set is a PWM mode. In a PWM mode, force strobes and matches leave the pins unchanged.
- R10: A write to the counter takes priority over a counting tick in the same cycle, and that cycle produces no match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| irq_ovf | output | 1 | Overflow flag |
| irq_cmp_a | output | 1 | Compare A flag |
| irq_cmp_b | output | 1 | Compare B flag |

## Verification
The bench forces a compare in CTC with the counter parked on compare A. A design that routed the strobe through the match path would zero the counter or raise flag A there. It also strobes both channels in a PWM mode, where any pin that moves exposes a missing mode gate. A compare A value of 255 in CTC checks that the restart suppresses the overflow flag. A counter write issued while the counter runs at full rate shows whether the write or the increment wins. Windows of exactly ten prescaled periods for every division, plus the two unused select codes, catch a wrong prescaler tap or a code that should have stopped the counter.

// File: rtl/fct_pkg.sv
package fct_pkg;
  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_CMPA = 3'd2;
  localparam logic [2:0] ADDR_CMPB = 3'd3;
  localparam logic [2:0] ADDR_CNT  = 3'd4;
  localparam logic [2:0] ADDR_FLG  = 3'd5;

  localparam logic [2:0] WGM_CTC = 3'b010;

  typedef enum logic [1:0] {
    PIN_OFF = 2'b00,
    PIN_TOG = 2'b01,
    PIN_CLR = 2'b10,
    PIN_SET = 2'b11
  } pin_act_e;
endpackage

// File: rtl/fct_prescaler.sv
module fct_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] csel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;
  logic             run;

  always_comb begin
    pre_d = pre_q + 1'b1;
    run   = 1'b1;
    mask  = '0;
    case (csel)
      3'b001: mask = '0;
      3'b010: mask = PRE_W'((1 << 3) - 1);
      3'b011: mask = PRE_W'((1 << 6) - 1);
      3'b100: mask = PRE_W'((1 << 8) - 1);
      3'b101: mask = PRE_W'((1 << 10) - 1);
      default: run = 1'b0;
    endcase
    tick = run && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3: with divide-by-8 held, two ticks never come back to back
  a_r3_div8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && csel == 3'b010 && $past(csel) == 3'b010) |-> !$past(tick));
endmodule

// File: rtl/fct_counter.sv
module fct_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ctc,
  input  logic [DW-1:0] cmp_a,
  input  logic [DW-1:0] cmp_b,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt,
  output logic          hit_a,
  output logic          hit_b,
  output logic          wrap
);
  localparam logic [DW-1:0] CNT_MAX = '1;

  logic [DW-1:0] cnt_q, cnt_d;
  logic          live, restart;

  always_comb begin
    live    = tick && !load;
    hit_a   = live && (cnt_q == cmp_a);
    hit_b   = live && (cnt_q == cmp_b);
    restart = ctc && hit_a;
    wrap    = live && !restart && (cnt_q == CNT_MAX);
    cnt_d   = cnt_q;
    if (load)         cnt_d = load_val;
    else if (restart) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R5: a CTC match on channel A restarts the count at zero
  a_r5_ctc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctc && !load && cnt_q == cmp_a) |=> (cnt_q == '0));
  // R4: a wrap event lands on zero
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  // R10: a counter write beats the tick
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/fct_outpin.sv
module fct_outpin (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] act_sel,
  input  logic       pwm,
  input  logic       hit,
  input  logic       force_hit,
  output logic       wave
);
  import fct_pkg::*;

  logic     pin_q, pin_d;
  pin_act_e act;
  logic     fire;

  always_comb begin
    act   = pin_act_e'(act_sel);
    fire  = !pwm && (hit || force_hit);
    pin_d = pin_q;
    if (fire) begin
      case (act)
        PIN_TOG: pin_d = ~pin_q;
        PIN_CLR: pin_d = 1'b0;
        PIN_SET: pin_d = 1'b1;
        default: pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign wave = (act != PIN_OFF) && pin_q;

  // R9: in PWM modes the pin state is frozen
  a_r9_pwm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pwm |=> $stable(pin_q));
  // R7: a disconnected channel keeps its pin state
  a_r7_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sel == 2'b00) |=> $stable(pin_q));
endmodule

// File: rtl/fc_timer8.sv
module fc_timer8 #(
  parameter int DW    = 8,
  parameter int PRE_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          wave_a,
  output logic          wave_b,
  output logic          irq_ovf,
  output logic          irq_cmp_a,
  output logic          irq_cmp_b
);
  import fct_pkg::*;

  localparam int NCH = 2;

  logic [1:0]    rst_pipe;
  logic          rst_n_s;
  logic [DW-1:0] mode_q, mode_d;
  logic [3:0]    ctrl_q, ctrl_d;
  logic [DW-1:0] cmp_q [NCH];
  logic [DW-1:0] cmp_d [NCH];
  logic [2:0]    flg_q, flg_d;
  logic [2:0]    flg_clr;
  logic          wr_mode, wr_ctrl, wr_cnt, wr_flg;
  logic [2:0]    wgm;
  logic          ctc, pwm, tick, wrap;
  logic [DW-1:0] cnt;
  logic [NCH-1:0] hit, frc, wave;
  logic [1:0]    act_sel [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  always_comb begin
    wr_mode = wr_en && (wr_addr == ADDR_MODE);
    wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    wr_cnt  = wr_en && (wr_addr == ADDR_CNT);
    wr_flg  = wr_en && (wr_addr == ADDR_FLG);
    wgm     = {ctrl_q[3], mode_q[1:0]};
    ctc     = (wgm == WGM_CTC);
    pwm     = wgm[0];
    frc[0]  = wr_ctrl && wr_data[7];
    frc[1]  = wr_ctrl && wr_data[6];
    act_sel[0] = mode_q[7:6];
    act_sel[1] = mode_q[5:4];
    mode_d  = wr_mode ? wr_data : mode_q;
    ctrl_d  = wr_ctrl ? wr_data[3:0] : ctrl_q;
    cmp_d[0] = (wr_en && wr_addr == ADDR_CMPA) ? wr_data : cmp_q[0];
    cmp_d[1] = (wr_en && wr_addr == ADDR_CMPB) ? wr_data : cmp_q[1];
    flg_clr = wr_flg ? wr_data[2:0] : 3'b000;
    flg_d   = (flg_q & ~flg_clr) | {hit[1], hit[0], wrap};
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= '0;
      ctrl_q <= '0;
      flg_q  <= '0;
      for (int i = 0; i < NCH; i++) cmp_q[i] <= '0;
    end else begin
      mode_q <= mode_d;
      ctrl_q <= ctrl_d;
      flg_q  <= flg_d;
      for (int i = 0; i < NCH; i++) cmp_q[i] <= cmp_d[i];
    end
  end

  fct_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .csel(ctrl_q[2:0]), .tick(tick)
  );

  fct_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .ctc(ctc),
    .cmp_a(cmp_q[0]), .cmp_b(cmp_q[1]),
    .load(wr_cnt), .load_val(wr_data),
    .cnt(cnt), .hit_a(hit[0]), .hit_b(hit[1]), .wrap(wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fct_outpin u_pin (
      .clk(clk), .rst_n(rst_n_s), .act_sel(act_sel[c]), .pwm(pwm),
      .hit(hit[c]), .force_hit(frc[c]), .wave(wave[c])
    );
  end

  always_comb begin
    case (rd_addr)
      ADDR_MODE: rd_data = mode_q;
      ADDR_CTRL: rd_data = {{(DW-4){1'b0}}, ctrl_q};
      ADDR_CMPA: rd_data = cmp_q[0];
      ADDR_CMPB: rd_data = cmp_q[1];
      ADDR_CNT:  rd_data = cnt;
      ADDR_FLG:  rd_data = {{(DW-3){1'b0}}, flg_q};
      default:   rd_data = '0;
    endcase
  end

  assign wave_a    = wave[0];
  assign wave_b    = wave[1];
  assign irq_ovf   = flg_q[0];
  assign irq_cmp_a = flg_q[1];
  assign irq_cmp_b = flg_q[2];

  // R2: strobe and reserved positions never read back
  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_addr == ADDR_CTRL) |-> (rd_data[7:4] == 4'b0000));
  // R8: a forced compare alone leaves flag A untouched
  a_r8_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frc[0] && !hit[0]) |=> (irq_cmp_a == $past(irq_cmp_a)));
  // R6: a genuine channel B match leaves its flag raised
  a_r6_flag_b_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    hit[1] |=> irq_cmp_b);
  // R4: a wrap raises the overflow flag
  a_r4_ovf_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    wrap |=> irq_ovf);
endmodule

// File: tb/fc_timer8_bench.sv
`timescale 1ns/1ps
module fc_timer8_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic       wave_a, wave_b, irq_ovf, irq_cmp_a, irq_cmp_b;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  fc_timer8 u_fc_timer8 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wave_a(wave_a), .wave_b(wave_b), .irq_ovf(irq_ovf),
    .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b)
  );

  // fields: ctc, start count, cmp A, cmp B, ticks, expected count, expected flags
  localparam logic [55:0] TV [0:6] = '{
    {8'd0, 8'd10,  8'd200, 8'd250, 8'd5,  8'd15, 8'd0},
    {8'd0, 8'd250, 8'd3,   8'd100, 8'd10, 8'd4,  8'd3},
    {8'd1, 8'd0,   8'd5,   8'd200, 8'd6,  8'd0,  8'd2},
    {8'd1, 8'd0,   8'd5,   8'd3,   8'd8,  8'd2,  8'd6},
    {8'd1, 8'd250, 8'd255, 8'd100, 8'd6,  8'd0,  8'd2},
    {8'd1, 8'd20,  8'd5,   8'd100, 8'd3,  8'd23, 8'd0},
    {8'd0, 8'd255, 8'd255, 8'd0,   8'd1,  8'd0,  8'd3}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // exactly n rising edges with the chosen select active
  task automatic run(input logic [2:0] cs, input int n);
    wr(3'd1, {5'b0, cs});
    repeat (n - 1) @(negedge clk);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] cnt0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1", "register after reset", d, 0);
    end
    chk("R1", "wave_a after reset", wave_a, 0);
    chk("R1", "wave_b after reset", wave_b, 0);
    chk("R1", "flags after reset", {irq_cmp_b, irq_cmp_a, irq_ovf}, 0);

    // R4 R5 R6 vector table at full rate
    for (int i = 0; i < 7; i++) begin
      logic [55:0] v;
      v = TV[i];
      wr(3'd0, v[55:48] != 0 ? 8'h02 : 8'h00);
      wr(3'd4, v[47:40]);
      wr(3'd2, v[39:32]);
      wr(3'd3, v[31:24]);
      wr(3'd5, 8'h07);
      rd(3'd5, d);
      chk("R6", "flags cleared by write-one", d, 0);
      run(3'b001, int'(v[23:16]));
      rd(3'd4, d);
      chk(v[55:48] != 0 ? "R5" : "R4", $sformatf("vector %0d count", i), d, v[15:8]);
      rd(3'd5, d);
      chk("R6", $sformatf("vector %0d flags", i), d, v[7:0]);
    end

    // R2 readback
    wr(3'd1, 8'hC0);
    rd(3'd1, d);
    chk("R2", "force bits read back", d, 8'h00);
    wr(3'd1, 8'h38);
    rd(3'd1, d);
    chk("R2", "reserved bits read back", d, 8'h08);
    wr(3'd1, 8'h00);

    // R8 forced compare, normal mode: A toggles, B clears
    wr(3'd5, 8'h07);
    wr(3'd0, 8'b01_10_0000);
    wr(3'd4, 8'd7);
    wr(3'd2, 8'd7);
    wr(3'd1, 8'h80);
    chk("R8", "wave_a after force toggle", wave_a, 1);
    chk("R8", "wave_b untouched", wave_b, 0);
    rd(3'd5, d);
    chk("R8", "no flag from force", d, 0);
    // R8 in CTC with count equal to compare A
    wr(3'd0, 8'b01_11_0010);
    wr(3'd1, 8'h40);
    chk("R8", "wave_b after force set", wave_b, 1);
    wr(3'd1, 8'h80);
    chk("R8", "wave_a after second toggle", wave_a, 0);
    rd(3'd4, d);
    chk("R8", "count kept in CTC", d, 7);
    rd(3'd5, d);
    chk("R8", "no flag in CTC force", d, 0);

    // R9 PWM mode ignores strobes
    wr(3'd0, 8'b01_01_0001);
    wr(3'd1, 8'hC0);
    chk("R9", "wave_a held in PWM", wave_a, 0);
    chk("R9", "wave_b held in PWM", wave_b, 1);

    // R7 genuine match toggles A; B disconnected reads low
    wr(3'd0, 8'b01_00_0010);
    chk("R7", "disconnected wave_b low", wave_b, 0);
    wr(3'd4, 8'd0);
    wr(3'd2, 8'd3);
    run(3'b001, 4);
    chk("R7", "wave_a toggled by match", wave_a, 1);
    wr(3'd0, 8'b10_00_0010);
    run(3'b001, 4);
    chk("R7", "wave_a cleared by match", wave_a, 0);
    wr(3'd0, 8'b00_11_0010);
    wr(3'd3, 8'd2);
    run(3'b001, 4);
    chk("R7", "wave_b set by match", wave_b, 1);

    // R10 counter write wins over tick
    wr(3'd0, 8'h00);
    wr(3'd4, 8'd50);
    wr(3'd1, 8'h01);
    wr(3'd4, 8'd100);
    wr(3'd1, 8'h00);
    rd(3'd4, d);
    chk("R10", "count after write during run", d, 101);

    // R3 prescaler divisions and stopped codes
    for (int k = 0; k < 4; k++) begin
      int div;
      div = (k == 0) ? 8 : (k == 1) ? 64 : (k == 2) ? 256 : 1024;
      wr(3'd4, 8'd0);
      run(3'(k + 2), 10 * div);
      rd(3'd4, d);
      chk("R3", $sformatf("ticks with divide %0d", div), d, 10);
    end
    for (int k = 0; k < 3; k++) begin
      logic [2:0] cs;
      cs = (k == 0) ? 3'b000 : (k == 1) ? 3'b110 : 3'b111;
      wr(3'd4, 8'd40);
      rd(3'd4, cnt0);
      run(cs, 100);
      rd(3'd4, d);
      chk("R3", $sformatf("stopped code %0d", cs), d, cnt0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule